// File: doc/BRIEF.md
# Indirect Extended Register Access Port

This block sits on a simple management register bus and opens a large extended register space through two direct registers. The access-control register, at direct address 0x0D, holds an access type in its top two bits and a device address in its low five bits. The address/data register, at direct address 0x0E, either loads a latched extended address or reads and writes the extended register that this address selects. The address/data register's role depends on the access type.

Software writes a target register number through 0x0E while the access type is "address". It then switches the control register to one of the three data types and reads or writes 0x0E. Two of the data types step the latched address forward, so a run of neighbouring registers can be walked without reloading the address. The extended file holds ten 8-bit configuration registers at extended addresses 0x1E0 to 0x1E9, each with its own reset value. Only device address 0x1F is served. Read data is combinational from the current address and state. Writes and address steps take effect at the rising clock edge.

Top module: `mmd_indirect_port`

## Requirements
- R1: After reset the control register reads 0x0000. The extended registers 0x1E0 to 0x1E9 hold 0xC5, 0x67, 0x70, 0x03, 0x20, 0x00, 0x40, 0x00, 0x40 and 0x20, in that address order.
- R2: A write to direct address 0x0D stores the access type from bits 15:14 and the device address from bits 4:0. A read of 0x0D returns those fields and zero in bits 13:5.
- R3: With access type 00 (address), a write to 0x0E loads the latched extended address and leaves the register file unchanged. A read of 0x0E returns the latched address.
- R4: With access type 01 (data), a write to 0x0E updates the extended register at the latched address. A read of 0x0E returns that register. Neither access changes the address.
- R5: With access type 10, the latched address increments by one after every read or write of 0x0E. It wraps from 0xFFFF to 0x0000.
- R6: With access type 11, the latched address increments by one after a write of 0x0E and stays unchanged after a read.
- R7: When the device address field is not 0x1F, a read of 0x0E returns zero. A write to 0x0E then has no effect on the latched address or the registers, and no increment occurs.
- R8: Bits 15:8 of every extended register read as zero, and write data in those bits is discarded.
- R9: A data access to an extended address outside 0x1E0 to 0x1E9 reads zero and its write is ignored. A post-increment access there still steps the address.
- R10: Any direct address other than 0x0D and 0x0E reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Direct register address |
| wrEn | input | 1 | Write strobe for the addressed direct register |
| rdEn | input | 1 | Read strobe; marks a consuming read for post-increment |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed direct register (combinational) |

## Verification
The corner cases that matter most are the increment rules. A design that also stepped on reads in type 11 would skip every other register in a read-back loop. A design that stepped on a rejected device address would drift the pointer, which later corrupts a neighbouring register. The bench walks the whole file with type 10, wraps the address past 0xFFFF, and mixes reads and writes in type 11. It issues data writes under a wrong device address and outside the window, then reads the file back, so a write that leaked through shows up as a changed register. A long stretch of mixed random traffic is compared against a behavioural model on every cycle. That traffic catches a reserved byte that reads back non-zero and an access-type decode that is off by one.

// File: rtl/mmd_indirect_pkg.sv
package mmd_indirect_pkg;

  localparam int LED_W = 8;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    ACC_ADDR   = 2'b00,
    ACC_DATA   = 2'b01,
    ACC_INC_RW = 2'b10,
    ACC_INC_WR = 2'b11
  } accType_e;

  typedef struct packed {
    logic             hit;
    logic             wrStb;
    logic [IDX_W-1:0] idx;
    logic [LED_W-1:0] wrData;
  } extStrobe_t;

  function automatic logic [LED_W-1:0] ledResetVal(input int i);
    case (i)
      0: return 8'hC5;
      1: return 8'h67;
      2: return 8'h70;
      3: return 8'h03;
      4: return 8'h20;
      5: return 8'h00;
      6: return 8'h40;
      7: return 8'h00;
      8: return 8'h40;
      9: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mmd_indirect_ctrl.sv
module mmd_indirect_ctrl
  import mmd_indirect_pkg::*;
#(
  parameter int DIR_W     = 5,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int DEV_W     = 5,
  parameter int CTRL_ADDR = 'h0D,
  parameter int DATA_ADDR = 'h0E,
  parameter int DEV_ID    = 'h1F,
  parameter int BASE      = 'h1E0,
  parameter int NUM_REGS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIR_W-1:0]  regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] fileRdVal,
  output logic [DATA_W-1:0] rdData,
  output extStrobe_t        stb,
  output logic [ADDR_W-1:0] extAddr,
  output accType_e          ctrlType,
  output logic [DEV_W-1:0]  ctrlDev
);
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'(BASE + NUM_REGS);
  localparam int                PAD_W     = DATA_W - 2 - DEV_W;

  logic ctrlSel, dataSel, devOk, inWin, dataWr, dataRd, stepAddr;

  assign ctrlSel = (regAddr == DIR_W'(CTRL_ADDR));
  assign dataSel = (regAddr == DIR_W'(DATA_ADDR));
  assign devOk   = (ctrlDev == DEV_W'(DEV_ID));
  assign inWin   = (extAddr >= BASE_ADDR) && (extAddr < END_ADDR);
  assign dataWr  = dataSel && wrEn && devOk;
  assign dataRd  = dataSel && rdEn && devOk;

  always_comb begin
    unique case (ctrlType)
      ACC_INC_RW: stepAddr = dataWr || dataRd;
      ACC_INC_WR: stepAddr = dataWr;
      default:    stepAddr = 1'b0;
    endcase
  end

  always_comb begin
    stb.hit    = inWin;
    stb.wrStb  = dataWr && (ctrlType != ACC_ADDR) && inWin;
    stb.idx    = IDX_W'(extAddr - BASE_ADDR);
    stb.wrData = wrData[LED_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlType <= ACC_ADDR;
      ctrlDev  <= '0;
      extAddr  <= '0;
    end else begin
      if (ctrlSel && wrEn) begin
        ctrlType <= accType_e'(wrData[DATA_W-1 -: 2]);
        ctrlDev  <= wrData[DEV_W-1:0];
      end
      if (dataWr && ctrlType == ACC_ADDR) extAddr <= wrData[ADDR_W-1:0];
      else if (stepAddr)                  extAddr <= extAddr + ADDR_W'(1);
    end
  end

  always_comb begin
    rdData = '0;
    if (ctrlSel) begin
      rdData = {ctrlType, {PAD_W{1'b0}}, ctrlDev};
    end else if (dataSel && devOk) begin
      if (ctrlType == ACC_ADDR) rdData = DATA_W'(extAddr);
      else                      rdData = fileRdVal;
    end
  end
endmodule

// File: rtl/mmd_indirect_file.sv
module mmd_indirect_file
  import mmd_indirect_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  extStrobe_t        stb,
  output logic [DATA_W-1:0] fileRdVal
);
  logic [LED_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= ledResetVal(i);
    end else if (stb.wrStb) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (stb.idx == IDX_W'(i)) regs[i] <= stb.wrData;
    end
  end

  always_comb begin
    fileRdVal = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (stb.hit && stb.idx == IDX_W'(i)) fileRdVal = DATA_W'(regs[i]);
  end
endmodule

// File: rtl/mmd_indirect_port.sv
module mmd_indirect_port
  import mmd_indirect_pkg::*;
#(
  parameter int DIR_W    = 5,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int DEV_W    = 5,
  parameter int NUM_REGS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIR_W-1:0]  regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  extStrobe_t        stb;
  logic [DATA_W-1:0] fileRdVal;
  logic [ADDR_W-1:0] extAddr;
  accType_e          ctrlType;
  logic [DEV_W-1:0]  ctrlDev;

  mmd_indirect_ctrl #(
    .DIR_W(DIR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DEV_W(DEV_W), .NUM_REGS(NUM_REGS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .fileRdVal(fileRdVal), .rdData(rdData), .stb(stb),
    .extAddr(extAddr), .ctrlType(ctrlType), .ctrlDev(ctrlDev)
  );

  mmd_indirect_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_file (
    .clk(clk), .rstN(rstN), .stb(stb), .fileRdVal(fileRdVal)
  );
endmodule

// File: rtl/mmd_indirect_port_chk.sv
module mmd_indirect_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  regAddr,
  input logic        wrEn,
  input logic        rdEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic [15:0] extAddr,
  input logic [1:0]  ctrlType,
  input logic [4:0]  ctrlDev
);
  logic dataSel, devOk;
  assign dataSel = (regAddr == 5'h0E);
  assign devOk   = (ctrlDev == 5'h1F);

  assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 5'h0D) |-> (rdData[13:5] == 9'd0));

  assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && wrEn && devOk && ctrlType == 2'b00) |=> (extAddr == $past(wrData)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && devOk && ctrlType == 2'b01) |=> $stable(extAddr));

  assert_step_rw_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && (wrEn || rdEn) && devOk && ctrlType == 2'b10)
      |=> (extAddr == $past(extAddr) + 16'd1));

  assert_read_nostep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && rdEn && !wrEn && ctrlType == 2'b11) |=> $stable(extAddr));

  assert_bad_dev_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && !devOk) |-> (rdData == 16'd0));

  assert_bad_dev_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && !devOk) |=> $stable(extAddr));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel && ctrlType != 2'b00) |-> (rdData[15:8] == 8'd0));

  assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!dataSel && regAddr != 5'h0D) |-> (rdData == 16'd0));
endmodule

bind mmd_indirect_port mmd_indirect_port_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .extAddr(extAddr),
  .ctrlType(ctrlType), .ctrlDev(ctrlDev)
);

// File: tb/mmd_indirect_port_tb.sv
module mmd_indirect_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mType = 0;
  int mDev = 0;
  int mAddr = 0;
  int mRegs[10] = '{'hC5, 'h67, 'h70, 'h03, 'h20, 'h00, 'h40, 'h00, 'h40, 'h20};

  always #5 clk = ~clk;

  mmd_indirect_port u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData)
  );

  function automatic int expRead(input int a);
    if (a == 'h0D) return (mType << 14) | mDev;
    if (a != 'h0E || mDev != 'h1F) return 0;
    if (mType == 0) return mAddr;
    if (mAddr >= 'h1E0 && mAddr <= 'h1E9) return mRegs[mAddr - 'h1E0];
    return 0;
  endfunction

  task automatic modelEdge(input int a, input bit we, input bit re, input int d);
    bit ok;
    ok = (a == 'h0E) && (mDev == 'h1F);
    if (a == 'h0D && we) begin
      mType = (d >> 14) & 3;
      mDev  = d & 'h1F;
    end else if (ok && we && mType == 0) begin
      mAddr = d & 'hFFFF;
    end else if (ok) begin
      if (we && mType != 0 && mAddr >= 'h1E0 && mAddr <= 'h1E9)
        mRegs[mAddr - 'h1E0] = d & 'hFF;
      if ((mType == 2 && (we || re)) || (mType == 3 && we))
        mAddr = (mAddr + 1) & 'hFFFF;
    end
  endtask

  task automatic op(input int a, input bit we, input bit re, input int d, input string tag);
    int e;
    @(negedge clk);
    regAddr = 5'(a);
    wrEn = we;
    rdEn = re;
    wrData = 16'(d);
    #1;
    e = expRead(a);
    vectors++;
    if (rdData !== 16'(e)) begin
      fails++;
      $display("FAIL %s: addr 0x%0h rdData 0x%04h expected 0x%04h", tag, a, rdData, 16'(e));
    end
    @(posedge clk);
    modelEdge(a, we, re, d);
  endtask

  task automatic setCtrl(input int t, input int dev, input string tag);
    op('h0D, 1, 0, (t << 14) | dev, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    op('h0D, 0, 1, 0, "R1");            // control reads zero after reset
    op('h0E, 0, 1, 0, "R7");            // device 0 is rejected
    setCtrl(0, 'h1F, "R2");
    op('h0D, 0, 1, 0, "R2");
    op('h0D, 1, 0, 'h3FFF, "R2");       // pad bits must not stick
    op('h0D, 0, 1, 0, "R2");
    setCtrl(0, 'h1F, "R3");
    op('h0E, 1, 0, 'h1E0, "R3");
    op('h0E, 0, 1, 0, "R3");
    setCtrl(2, 'h1F, "R5");
    for (int i = 0; i < 10; i++) op('h0E, 0, 1, 0, "R1");  // walk reset values
    op('h0E, 0, 1, 0, "R9");            // 0x1EA, outside
    setCtrl(0, 'h1F, "R4");
    op('h0E, 1, 0, 'h1E3, "R4");
    setCtrl(1, 'h1F, "R4");
    op('h0E, 1, 0, 'hABCD, "R8");
    op('h0E, 0, 1, 0, "R8");
    op('h0E, 0, 1, 0, "R4");
    setCtrl(0, 'h1F, "R6");
    op('h0E, 1, 0, 'h1E5, "R6");
    setCtrl(3, 'h1F, "R6");
    op('h0E, 0, 1, 0, "R6");
    op('h0E, 0, 1, 0, "R6");
    op('h0E, 1, 0, 'h11, "R6");
    op('h0E, 1, 0, 'h22, "R6");
    op('h0E, 0, 1, 0, "R6");
    setCtrl(0, 'h1F, "R6");
    op('h0E, 0, 1, 0, "R6");            // pointer 0x1E7
    setCtrl(1, 'h05, "R7");
    op('h0E, 1, 0, 'h99, "R7");
    op('h0E, 0, 1, 0, "R7");
    setCtrl(0, 'h05, "R7");
    op('h0E, 1, 0, 'h1E0, "R7");
    setCtrl(0, 'h1F, "R7");
    op('h0E, 0, 1, 0, "R7");            // still 0x1E7
    op('h0E, 1, 0, 'h1EA, "R9");
    setCtrl(1, 'h1F, "R9");
    op('h0E, 1, 0, 'h55, "R9");
    op('h0E, 0, 1, 0, "R9");
    setCtrl(0, 'h1F, "R5");
    op('h0E, 1, 0, 'hFFFF, "R5");
    setCtrl(2, 'h1F, "R5");
    op('h0E, 0, 1, 0, "R5");
    setCtrl(0, 'h1F, "R5");
    op('h0E, 0, 1, 0, "R5");            // wrapped to 0
    op('h03, 1, 0, 'h1234, "R10");
    op('h03, 0, 1, 0, "R10");
    op('h1F, 1, 0, 'hFFFF, "R10");
    op('h0D, 0, 1, 0, "R10");
    op('h0E, 0, 1, 0, "R10");
    setCtrl(0, 'h1F, "R1");
    op('h0E, 1, 0, 'h1E0, "R1");
    setCtrl(2, 'h1F, "R1");
    for (int i = 0; i < 10; i++) op('h0E, 0, 1, 0, "R4");  // full read-back

    for (int n = 0; n < 3000; n++) begin
      int sel;
      int d;
      sel = $urandom_range(0, 9);
      if (sel < 3) begin
        d = ($urandom_range(0, 3) << 14) | (($urandom_range(0, 7) == 0) ? $urandom_range(0, 31) : 'h1F);
        op('h0D, 1, 0, d, "R2");
      end else if (sel < 9) begin
        d = (mType == 0) ? ('h1DE + $urandom_range(0, 14)) : $urandom_range(0, 'hFFFF);
        op('h0E, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, "R5");
      end else begin
        op($urandom_range(0, 31), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 'hFFFF), "R10");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule